// File: doc/BRIEF.md
# Locally Connected Two-Layer Perceptron Face Classifier

This block decides whether one 32x32 image window holds a face. Its input is the window's 128 wavelet features: eight 4x4 subband images, each 16 signed values. A host writes the features through a simple write port and then pulses a start input. The block computes the result from fixed-point constants. It raises a one-cycle done flag together with a signed score and a face bit. The score and the face bit hold their values until the next result.

The first layer has eight hidden neurons. Each hidden neuron reads only its own subband image. It owns a constant weight ROM, a 16-bit operand register that holds one weight and one feature, a multiplier, an accumulator and a tanh lookup table. All eight neurons run in parallel for 16 multiply-accumulate cycles. A counter then drives a multiplexer that passes one hidden output per clock to the single output neuron. The output neuron is linear and fully connected to the eight hidden outputs.

Top module: `face_mlp_classifier`

## Requirements
- R1: After reset, done_o, score_o and face_o are all 0.
- R2: A write with feat_we_i high stores feat_data_i, a signed Q1.7 value, as feature k of subband n, where n = feat_addr_i[6:4] and k = feat_addr_i[3:0].
- R3: Hidden neuron n forms pre_n = (n-4)*2048 + sum over k of w(n,k)*x(n,k), in units of 2^-14, with w(n,k) = ((29n + 13k + 7) mod 255) - 127.
- R4: The activation index of neuron n is pre_n shifted arithmetically right by 9 bits, then saturated to the range -128..127.
- R5: The hidden output for index i with a = |i| is y = 4a for a<16, y = 64 + floor(3(a-16)/2) for a<48, y = 112 + floor((a-48)/4) for a<96, and y = 127 otherwise. The sign of the output is the sign of i.
- R6: score_o = 512 + sum over j of v(j)*h_j, a 20-bit signed value, with v(j) = ((45j + 17) mod 97) - 48.
- R7: face_o is 1 exactly when score_o is greater than zero.
- R8: done_o is high for one cycle, 28 rising edges after the edge that captures start_i. score_o and face_o change only at that point and then hold.
- R9: A start_i pulse while a classification is running is ignored. It produces no extra result and does not disturb the running one.
- R10: The features of one subband affect only the hidden neuron that owns that subband. A window whose only nonzero features lie in one subband moves just that neuron's output away from its bias value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| feat_we_i | input | 1 | Feature write enable |
| feat_addr_i | input | 7 | Feature address: subband in the upper 3 bits, element in the lower 4 bits |
| feat_data_i | input | 8 | Feature value, signed Q1.7 |
| start_i | input | 1 | Start pulse |
| done_o | output | 1 | One-cycle result strobe |
| score_o | output | 20 | Signed output-neuron sum, Q6.14 |
| face_o | output | 1 | 1 when the score is positive |

## Verification
The assertions assume that features are written only while the block is idle. They also assume that start_i is a single-cycle pulse. The one exception is the deliberate start given during a run. The bench loads all 128 features before each start and waits for every result before the next load. Its only start during a run comes a few cycles into the multiply-accumulate phase. Feature values stay inside the signed 8-bit range. One pattern matches every input sign to its weight's sign, which drives the hidden sums into index saturation.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int N_HID     = 8;
  localparam int N_TAP     = 16;
  localparam int D_W       = 8;
  localparam int ACC_W     = 20;
  localparam int IDX_SHIFT = 9;
  localparam int TAP_AW    = $clog2(N_TAP);
  localparam int HID_AW    = $clog2(N_HID);
  localparam int FEAT_AW   = TAP_AW + HID_AW;
  localparam int PROD_W    = 2 * D_W;
  localparam int LATENCY   = N_TAP + N_HID + 4;

  function automatic logic signed [D_W-1:0] hid_weight(int n, int k);
    int v;
    v = ((n * 29 + k * 13 + 7) % 255) - 127;
    return D_W'(v);
  endfunction

  function automatic logic signed [ACC_W-1:0] hid_bias(int n);
    return ACC_W'((n - 4) * 2048);
  endfunction

  function automatic logic signed [D_W-1:0] out_weight(int j);
    int v;
    v = ((j * 45 + 17) % 97) - 48;
    return D_W'(v);
  endfunction

  function automatic logic signed [ACC_W-1:0] out_bias();
    return ACC_W'(512);
  endfunction

  // piecewise tanh, index in 1/32 steps, result Q1.7
  function automatic logic signed [D_W-1:0] tanh_q(int idx);
    int a, y;
    a = (idx < 0) ? -idx : idx;
    if (a < 16)      y = a * 4;
    else if (a < 48) y = 64 + ((a - 16) * 3) / 2;
    else if (a < 96) y = 112 + (a - 48) / 4;
    else             y = 127;
    return D_W'((idx < 0) ? -y : y);
  endfunction

  typedef enum logic [2:0] {
    S_IDLE, S_MAC, S_DRAIN, S_ACT, S_OUT, S_ODRAIN, S_FIN
  } mlp_state_e;
endpackage

// File: rtl/mlp_tanh_lut.sv
module mlp_tanh_lut
  import mlp_pkg::*;
(
  input  logic signed [D_W-1:0] idx_i,
  output logic signed [D_W-1:0] val_o
);
  localparam int DEPTH = 1 << D_W;

  logic signed [D_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam int SIDX = (g >= DEPTH / 2) ? g - DEPTH : g;
    assign rom[g] = tanh_q(SIDX);
  end

  assign val_o = rom[$unsigned(idx_i)];
endmodule

// File: rtl/mlp_hidden_neuron.sv
module mlp_hidden_neuron
  import mlp_pkg::*;
#(
  parameter int NID = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [TAP_AW-1:0]        wr_tap_i,
  input  logic signed [D_W-1:0]    wr_data_i,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [TAP_AW-1:0]        tap_i,
  input  logic                     act_i,
  output logic signed [D_W-1:0]    h_o
);
  logic signed [D_W-1:0]   feat_q [N_TAP];
  logic signed [D_W-1:0]   w_rom  [N_TAP];
  logic [PROD_W-1:0]       op_q;
  logic                    op_vld_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] shifted;
  logic signed [D_W-1:0]   idx;
  logic signed [D_W-1:0]   act_val;
  logic signed [D_W-1:0]   h_q;

  for (genvar g = 0; g < N_TAP; g++) begin : g_wrom
    assign w_rom[g] = hid_weight(NID, g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TAP; i++) feat_q[i] <= '0;
    end else if (wr_en_i) begin
      feat_q[wr_tap_i] <= wr_data_i;
    end
  end

  // weight and feature share one 16-bit operand register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      op_vld_q <= 1'b0;
    end else begin
      op_vld_q <= load_i;
      if (load_i) op_q <= {w_rom[tap_i], feat_q[tap_i]};
    end
  end

  assign prod = $signed(op_q[PROD_W-1:D_W]) * $signed(op_q[D_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= hid_bias(NID);
    else if (op_vld_q) acc_q <= acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  assign shifted = acc_q >>> IDX_SHIFT;

  always_comb begin
    if (shifted > ACC_W'(127))        idx = 8'sd127;
    else if (shifted < -ACC_W'(128))  idx = -8'sd128;
    else                              idx = shifted[D_W-1:0];
  end

  mlp_tanh_lut u_lut (
    .idx_i (idx),
    .val_o (act_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    h_q <= '0;
    else if (act_i) h_q <= act_val;
  end

  assign h_o = h_q;

  // R5
  act_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q != -8'sd128);

  // R4
  sat_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (idx[D_W-1] == acc_q[ACC_W-1]));
endmodule

// File: rtl/mlp_output_neuron.sv
module mlp_output_neuron
  import mlp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_HID*D_W-1:0]    h_vec_i,
  input  logic [HID_AW-1:0]       sel_i,
  input  logic                    clr_i,
  input  logic                    load_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [D_W-1:0]    h_arr [N_HID];
  logic signed [D_W-1:0]    v_rom [N_HID];
  logic [PROD_W-1:0]        op_q;
  logic                     op_vld_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q;

  for (genvar g = 0; g < N_HID; g++) begin : g_unpack
    assign h_arr[g] = h_vec_i[g*D_W +: D_W];
    assign v_rom[g] = out_weight(g);
  end

  // counter-selected hidden output, one per clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      op_vld_q <= 1'b0;
    end else begin
      op_vld_q <= load_i;
      if (load_i) op_q <= {v_rom[sel_i], h_arr[sel_i]};
    end
  end

  assign prod = $signed(op_q[PROD_W-1:D_W]) * $signed(op_q[D_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= out_bias();
    else if (op_vld_q) acc_q <= acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              hid_clr_o,
  output logic              hid_load_o,
  output logic [TAP_AW-1:0] tap_o,
  output logic              act_o,
  output logic              out_clr_o,
  output logic              out_load_o,
  output logic [HID_AW-1:0] sel_o,
  output logic              fin_o
);
  mlp_state_e        state_q;
  logic [TAP_AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_MAC;
          cnt_q   <= '0;
        end
        S_MAC: begin
          if (cnt_q == TAP_AW'(N_TAP - 1)) begin
            state_q <= S_DRAIN;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + TAP_AW'(1);
        end
        S_DRAIN: state_q <= S_ACT;
        S_ACT: begin
          state_q <= S_OUT;
          cnt_q   <= '0;
        end
        S_OUT: begin
          if (cnt_q == TAP_AW'(N_HID - 1)) begin
            state_q <= S_ODRAIN;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + TAP_AW'(1);
        end
        S_ODRAIN: state_q <= S_FIN;
        S_FIN:    state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign hid_clr_o  = (state_q == S_IDLE) && start_i;
  assign hid_load_o = (state_q == S_MAC);
  assign tap_o      = cnt_q;
  assign act_o      = (state_q == S_ACT);
  assign out_clr_o  = (state_q == S_ACT);
  assign out_load_o = (state_q == S_OUT);
  assign sel_o      = cnt_q[HID_AW-1:0];
  assign fin_o      = (state_q == S_FIN);

  // R9
  no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && state_q != S_FIN) |=> (state_q != S_IDLE));

  // R8
  mac_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MAC) |=> ((state_q == S_MAC && cnt_q == $past(cnt_q) + TAP_AW'(1))
                            || state_q == S_DRAIN));

  // R6
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hid_load_o, act_o, out_load_o, fin_o}));
endmodule

// File: rtl/face_mlp_classifier.sv
module face_mlp_classifier
  import mlp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               feat_we_i,
  input  logic [FEAT_AW-1:0] feat_addr_i,
  input  logic [D_W-1:0]     feat_data_i,
  input  logic               start_i,
  output logic               done_o,
  output logic [ACC_W-1:0]   score_o,
  output logic               face_o
);
  logic              hid_clr, hid_load, act, out_clr, out_load, fin;
  logic [TAP_AW-1:0] tap;
  logic [HID_AW-1:0] sel;
  logic [N_HID*D_W-1:0]    h_vec;
  logic signed [ACC_W-1:0] out_acc;
  logic                    done_q, face_q;
  logic signed [ACC_W-1:0] score_q;

  mlp_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .hid_clr_o  (hid_clr),
    .hid_load_o (hid_load),
    .tap_o      (tap),
    .act_o      (act),
    .out_clr_o  (out_clr),
    .out_load_o (out_load),
    .sel_o      (sel),
    .fin_o      (fin)
  );

  for (genvar n = 0; n < N_HID; n++) begin : g_hid
    logic wr_en;
    assign wr_en = feat_we_i && (feat_addr_i[FEAT_AW-1:TAP_AW] == HID_AW'(n));
    mlp_hidden_neuron #(.NID(n)) u_hid (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_tap_i  (feat_addr_i[TAP_AW-1:0]),
      .wr_data_i (feat_data_i),
      .clr_i     (hid_clr),
      .load_i    (hid_load),
      .tap_i     (tap),
      .act_i     (act),
      .h_o       (h_vec[n*D_W +: D_W])
    );
  end

  mlp_output_neuron u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .h_vec_i (h_vec),
    .sel_i   (sel),
    .clr_i   (out_clr),
    .load_i  (out_load),
    .acc_o   (out_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      score_q <= '0;
      face_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        score_q <= out_acc;
        face_q  <= (out_acc > 0);
      end
    end
  end

  assign done_o  = done_q;
  assign score_o = score_q;
  assign face_o  = face_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  score_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(score_o));

  // R7
  face_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    face_o == ($signed(score_o) > 0));
endmodule

// File: tb/face_mlp_classifier_bench.sv
module face_mlp_classifier_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        feat_we_i = 1'b0;
  logic [6:0]  feat_addr_i = '0;
  logic [7:0]  feat_data_i = '0;
  logic        start_i = 1'b0;
  logic        done_o;
  logic [19:0] score_o;
  logic        face_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int feat [128];
  int exp_q [$];
  string tag_q [$];
  int t0 = 0;
  int last_exp = 0;
  int n_done = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  face_mlp_classifier u_face_mlp_classifier (
    .clk_i, .rst_ni, .feat_we_i, .feat_addr_i, .feat_data_i,
    .start_i, .done_o, .score_o, .face_o
  );

  function automatic int wh(int n, int k);
    return ((n * 29 + k * 13 + 7) % 255) - 127;
  endfunction
  function automatic int wo(int j);
    return ((j * 45 + 17) % 97) - 48;
  endfunction
  function automatic int act_ref(int pre);
    int i, a, y;
    i = pre >>> 9;
    if (i > 127) i = 127;
    if (i < -128) i = -128;
    a = (i < 0) ? -i : i;
    y = 127;
    if (a < 96) y = 112 + (a - 48) / 4;
    if (a < 48) y = 64 + ((a - 16) * 3) / 2;
    if (a < 16) y = 4 * a;
    return (i < 0) ? -y : y;
  endfunction
  function automatic int model();
    int s, pre;
    s = 512;
    for (int n = 0; n < 8; n++) begin
      pre = (n - 4) * 2048;
      for (int k = 0; k < 16; k++) pre += wh(n, k) * feat[n*16 + k];
      s += wo(n) * act_ref(pre);
    end
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_job(string tag);
    for (int a = 0; a < 128; a++) begin
      @(negedge clk_i);
      feat_we_i   = 1'b1;
      feat_addr_i = 7'(a);
      feat_data_i = 8'(feat[a]);
    end
    @(negedge clk_i);
    feat_we_i = 1'b0;
    exp_q.push_back(model());
    tag_q.push_back(tag);
    t0 = cyc;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check({tag, " R8 hold"}, int'($signed(score_o)), last_exp);
  endtask

  // monitor: pop scoreboard on each result
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      n_done++;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected result actual=%0d expected=none", int'($signed(score_o)));
      end else begin
        int e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        last_exp = e;
        check({tg, " R6 score"}, int'($signed(score_o)), e);
        check({tg, " R7 face"}, int'(face_o), int'(e > 0));
        check({tg, " R8 latency"}, cyc - t0, 29);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 done", int'(done_o), 0);
    check("R1 score", int'(score_o), 0);
    check("R1 face", int'(face_o), 0);

    for (int a = 0; a < 128; a++) feat[a] = 0;
    run_job("zero R3");
    for (int a = 0; a < 128; a++) feat[a] = 127;
    run_job("max R5");
    for (int a = 0; a < 128; a++) feat[a] = -128;
    run_job("min R5");
    // R4: inputs follow weight sign -> index saturates
    for (int a = 0; a < 128; a++) feat[a] = (wh(a / 16, a % 16) < 0) ? -128 : 127;
    run_job("sat-pos R4");
    for (int a = 0; a < 128; a++) feat[a] = (wh(a / 16, a % 16) < 0) ? 127 : -128;
    run_job("sat-neg R4");
    for (int a = 0; a < 128; a++) feat[a] = (a % 2 == 0) ? 90 : -70;
    run_job("alt R2");
    seed = 12345;
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 128; a++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        feat[a] = ((seed >>> 8) % 256) - 128;
      end
      run_job("rand R3");
    end
    // R10: one subband only
    for (int a = 0; a < 128; a++) feat[a] = (a / 16 == 3) ? ((wh(3, a % 16) < 0) ? -100 : 100) : 0;
    run_job("local R10");
    for (int a = 0; a < 128; a++) feat[a] = (a / 16 == 6) ? (a % 16) * 8 - 60 : 0;
    run_job("local6 R10");

    // R9: extra start during a run
    for (int a = 0; a < 128; a++) feat[a] = (a * 7) % 200 - 100;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk_i);
      feat_we_i = 1'b1; feat_addr_i = 7'(a); feat_data_i = 8'(feat[a]);
    end
    @(negedge clk_i);
    feat_we_i = 1'b0;
    exp_q.push_back(model());
    tag_q.push_back("busy R9");
    t0 = cyc;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (60) @(negedge clk_i);
    check("R9 result count", n_done, 11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule